// File: doc/BRIEF.md
# Segment-Based Address Extension Unit

This unit sits between a processor core and the system interconnect. It turns a 32-bit logical address into a 36-bit physical address. A bank of sixteen programmable segment descriptors drives the translation. Each descriptor names a power-of-two logical window, the physical window it lands on, and six access-permission bits for user and supervisor read, write and execute. When several windows cover the same address, the descriptor with the highest index decides. An address that no window covers, or a request that lacks the permission it needs, returns a one-cycle fault and no address.

Software programs the descriptors through a small word-wide port. Each 64-bit descriptor is reached as two 32-bit halves. Every processor core gets its own instance of the unit. The result is registered, so a request presented on one clock edge is answered after that edge.

Top module: `addr_ext_unit`

## Requirements
- R1: A request sampled with `req_valid` high produces `rsp_valid` high in the next cycle, for exactly one cycle. A cycle without a request leaves `rsp_valid`, `rsp_hit` and `rsp_fault` low in the following cycle.
- R2: On a hit, the physical address is formed as follows. Its bits above the segment size come from the 36-bit physical base, which is `{high word[31:8], 12'h000}`. Its bits inside the segment come from the logical address unchanged.
- R3: The size code sits in low word bits [4:0]. A code c from 11 to 31 selects a window of 2^(c+1) bytes, so 11 gives 4 KB and 31 gives 4 GB. A code below 11 disables the descriptor.
- R4: When several enabled descriptors cover the address, the one with the highest index supplies the translation. If a higher descriptor does not cover the address, a lower one still applies.
- R5: The permission bits sit in high word bits [5:0], in this order: bit 0 user read, bit 1 user write, bit 2 user execute, bit 3 supervisor read, bit 4 supervisor write, bit 5 supervisor execute. The access kind is encoded 0 read, 1 write, 2 execute. A request is granted only when the bit for its kind and privilege is set.
- R6: A request that no descriptor covers, that is denied, or that carries kind code 3 gives `rsp_fault` = 1, `rsp_hit` = 0 and `rsp_paddr` = 0.
- R7: After reset, descriptor 0 maps logical 0x0000_0000–0x7FFF_FFFF one-to-one, with all permissions. Descriptor 1 maps logical 0x8000_0000–0xFFFF_FFFF to physical 0x8_0000_0000 upward, with all permissions. Every other descriptor reads as zero and is disabled. The readback values are 0x0000_001E and 0x0000_003F for descriptor 0, and 0x8000_001E and 0x8000_003F for descriptor 1.
- R8: Configuration writes keep only low word bits [31:12] and [4:0], and only high word bits [31:8] and [5:0]. The bits that are not kept read back as 0. A read selected by `cfg_hi` (0 low, 1 high) appears on `cfg_rdata` one cycle later and holds until the next read.
- R9: A configuration write and a request in the same cycle: the request uses the descriptor values from before the write. The write governs requests from the next cycle on.
- R10: Logical base bits below the window size are ignored when matching. Physical base bits below the window size are ignored when forming the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Logical address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| req_super | input | 1 | Supervisor privilege when 1 |
| cfg_en | input | 1 | Configuration access strobe |
| cfg_we | input | 1 | 1 write, 0 read |
| cfg_hi | input | 1 | Descriptor half select: 0 low word, 1 high word |
| cfg_idx | input | 4 | Descriptor index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered configuration read data |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation granted |
| rsp_fault | output | 1 | No covering descriptor, permission denied or reserved kind |
| rsp_paddr | output | 36 | Physical address, zero on fault |

## Verification
The bench builds the unit with its default of sixteen descriptors, so index 15 is reachable. That covers the full priority range from a 4 KB window on top of the reset mappings up to a 4 GB window that shadows every lower descriptor. With that width, the bench can overlap windows of different sizes. It can program bases whose low bits must be dropped, and it can remove both reset mappings to reach the no-match fault. The same-cycle race between a configuration write and a request is driven directly.

// File: rtl/aeu_pkg.sv
package aeu_pkg;
  localparam int LA_W   = 32;              // logical address width
  localparam int PA_W   = 36;              // physical address width
  localparam int PG_W   = 12;              // smallest window: 4 KB
  localparam int CODE_W = 5;               // size code width
  localparam int PERM_W = 6;               // permission bits
  localparam int WORD_W = 32;              // configuration word width
  localparam int LB_W   = LA_W - PG_W;     // stored logical base bits
  localparam int PB_W   = PA_W - PG_W;     // stored physical base bits
  localparam int PB_LSB = WORD_W - PB_W;   // physical base position in high word
  localparam int MIN_CODE = PG_W - 1;      // code of the 4 KB window

  typedef struct packed {
    logic [LB_W-1:0]   lbase;
    logic [CODE_W-1:0] code;
    logic [PB_W-1:0]   pbase;
    logic [PERM_W-1:0] perm;
  } seg_t;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_t;

  localparam int SUPER_OFS = 3;            // supervisor bits follow user bits
endpackage

// File: rtl/aeu_seg_bank.sv
module aeu_seg_bank
  import aeu_pkg::*;
#(
  parameter int NUM_SEG = 16,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_en,
  input  logic                  cfg_we,
  input  logic                  cfg_hi,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic [WORD_W-1:0]     cfg_wdata,
  output logic [WORD_W-1:0]     cfg_rdata,
  output seg_t [NUM_SEG-1:0]    segs
);
  // Reset contents: two 2 GB windows, all other descriptors cleared.
  localparam logic [CODE_W-1:0] RST_CODE  = CODE_W'(LA_W - 2);
  localparam logic [LB_W-1:0]   RST_LB1   = LB_W'(1) << (LB_W - 1);
  localparam logic [PB_W-1:0]   RST_PB1   = PB_W'(1) << (PB_W - 1);
  localparam logic [PERM_W-1:0] PERM_ALL  = '1;

  logic idx_ok;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] rdata_nxt;
  logic unused_wbits;

  assign idx_ok = (32'(cfg_idx) < NUM_SEG);
  assign unused_wbits = ^{cfg_wdata[PG_W-1:CODE_W], cfg_wdata[PB_LSB-1:PERM_W]};

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    seg_t cur, nxt, rst_val;
    logic sel, wr_lo, wr_hi;

    assign sel   = cfg_en && cfg_we && idx_ok && (32'(cfg_idx) == g);
    assign wr_lo = sel && !cfg_hi;
    assign wr_hi = sel && cfg_hi;

    always_comb begin
      rst_val = '0;
      if (g == 0) begin
        rst_val.code = RST_CODE;
        rst_val.perm = PERM_ALL;
      end else if (g == 1) begin
        rst_val.lbase = RST_LB1;
        rst_val.code  = RST_CODE;
        rst_val.pbase = RST_PB1;
        rst_val.perm  = PERM_ALL;
      end
    end

    always_comb begin
      nxt = cur;
      if (wr_lo) begin
        nxt.lbase = cfg_wdata[WORD_W-1:PG_W];
        nxt.code  = cfg_wdata[CODE_W-1:0];
      end
      if (wr_hi) begin
        nxt.pbase = cfg_wdata[WORD_W-1:PB_LSB];
        nxt.perm  = cfg_wdata[PERM_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur <= rst_val;
      end else if (wr_lo || wr_hi) begin
        cur <= nxt;
      end
    end

    assign segs[g] = cur;
  end

  always_comb begin
    rd_word = '0;
    if (idx_ok) begin
      if (cfg_hi) begin
        rd_word = {segs[cfg_idx].pbase, {(PB_LSB-PERM_W){1'b0}}, segs[cfg_idx].perm};
      end else begin
        rd_word = {segs[cfg_idx].lbase, {(PG_W-CODE_W){1'b0}}, segs[cfg_idx].code};
      end
    end
  end

  always_comb begin
    rdata_nxt = cfg_rdata;
    if (cfg_en && !cfg_we) begin
      rdata_nxt = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rdata <= '0;
    end else begin
      cfg_rdata <= rdata_nxt;
    end
  end
endmodule

// File: rtl/aeu_seg_slot.sv
module aeu_seg_slot
  import aeu_pkg::*;
(
  input  seg_t              seg,
  input  logic [LA_W-1:0]   addr,
  input  logic [PERM_W-1:0] need,
  output logic              match,
  output logic              allow,
  output logic [PA_W-1:0]   paddr
);
  logic              enabled;
  logic [5:0]        shamt;
  logic [LA_W:0]     span;
  logic [LA_W-1:0]   off_mask;
  logic [LA_W-1:0]   lbase_full;
  logic [PA_W-1:0]   pbase_full;
  logic              unused_span_top;

  always_comb begin
    enabled    = (seg.code >= CODE_W'(MIN_CODE));
    shamt      = 6'(seg.code) + 6'd1;
    span       = ((LA_W+1)'(1) << shamt) - (LA_W+1)'(1);
    off_mask   = span[LA_W-1:0];
    lbase_full = {seg.lbase, {PG_W{1'b0}}};
    pbase_full = {seg.pbase, {PG_W{1'b0}}};
    match      = enabled && ((addr & ~off_mask) == (lbase_full & ~off_mask));
    allow      = |(seg.perm & need);
    paddr      = (pbase_full & ~{{(PA_W-LA_W){1'b0}}, off_mask})
               | {{(PA_W-LA_W){1'b0}}, addr & off_mask};
  end

  assign unused_span_top = span[LA_W];
endmodule

// File: rtl/aeu_prio_pick.sv
module aeu_prio_pick #(
  parameter int NUM_SEG = 16,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input  logic [NUM_SEG-1:0] match,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  // Ascending scan: the last matching index, the highest, is kept.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (match[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/addr_ext_unit.sv
module addr_ext_unit
  import aeu_pkg::*;
#(
  parameter int NUM_SEG = 16,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic [1:0]        req_kind,
  input  logic              req_super,
  input  logic              cfg_en,
  input  logic              cfg_we,
  input  logic              cfg_hi,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [35:0]       rsp_paddr
);
  seg_t [NUM_SEG-1:0]      segs;
  logic [PERM_W-1:0]       need;
  logic [NUM_SEG-1:0]      slot_match;
  logic [NUM_SEG-1:0]      slot_allow;
  logic [PA_W-1:0]         slot_pa [NUM_SEG];
  logic                    found;
  logic [IDX_W-1:0]        win_idx;

  logic                    valid_nxt, hit_nxt, fault_nxt;
  logic [PA_W-1:0]         pa_nxt;

  aeu_seg_bank #(.NUM_SEG(NUM_SEG)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_we    (cfg_we),
    .cfg_hi    (cfg_hi),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .segs      (segs)
  );

  // Required permission bit, one-hot; reserved kind asks for none.
  always_comb begin
    need = '0;
    if (acc_t'(req_kind) != ACC_RSV) begin
      need = PERM_W'(1) << (3'(req_kind) + (req_super ? 3'(SUPER_OFS) : 3'd0));
    end
  end

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_slot
    aeu_seg_slot u_slot (
      .seg   (segs[g]),
      .addr  (req_addr),
      .need  (need),
      .match (slot_match[g]),
      .allow (slot_allow[g]),
      .paddr (slot_pa[g])
    );
  end

  aeu_prio_pick #(.NUM_SEG(NUM_SEG)) u_pick (
    .match (slot_match),
    .found (found),
    .idx   (win_idx)
  );

  always_comb begin
    valid_nxt = req_valid;
    hit_nxt   = req_valid && found && slot_allow[win_idx];
    fault_nxt = req_valid && !hit_nxt;
    pa_nxt    = hit_nxt ? slot_pa[win_idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= valid_nxt;
      rsp_hit   <= hit_nxt;
      rsp_fault <= fault_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_paddr <= '0;
    end else if (req_valid) begin
      rsp_paddr <= pa_nxt;
    end
  end
endmodule

// File: rtl/aeu_checker.sv
module aeu_checker #(
  parameter int NUM_SEG = 16,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [31:0]      req_addr,
  input logic [1:0]       req_kind,
  input logic             cfg_en,
  input logic             cfg_we,
  input logic [31:0]      cfg_rdata,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_fault,
  input logic [35:0]      rsp_paddr
);
  // R1
  req_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault));

  // R6
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_fault));

  // R6
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == 36'h0));

  // R6
  rsv_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b11) |=> rsp_fault);

  // R2
  page_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_valid) |=> (!rsp_hit || rsp_paddr[11:0] == $past(req_addr[11:0])));

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en || cfg_we) |=> $stable(cfg_rdata));
endmodule

bind addr_ext_unit aeu_checker #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_kind  (req_kind),
  .cfg_en    (cfg_en),
  .cfg_we    (cfg_we),
  .cfg_rdata (cfg_rdata),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_fault (rsp_fault),
  .rsp_paddr (rsp_paddr)
);

// File: tb/addr_ext_unit_test.sv
module addr_ext_unit_test;
  localparam int NSEG = 16;
  localparam int IW   = $clog2(NSEG);
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_EX = 2'd2, K_RSV = 2'd3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_super, cfg_en, cfg_we, cfg_hi;
  logic [31:0]   req_addr, cfg_wdata, cfg_rdata;
  logic [1:0]    req_kind;
  logic [IW-1:0] cfg_idx;
  logic          rsp_valid, rsp_hit, rsp_fault;
  logic [35:0]   rsp_paddr;

  addr_ext_unit #(.NUM_SEG(NSEG)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_super(req_super), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_hi(cfg_hi), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_lo [NSEG];
  logic [31:0] m_hi [NSEG];
  logic        e_valid, e_hit, e_fault;
  logic [35:0] e_pa;
  logic [31:0] e_rd;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: windows as integer ranges, highest index wins.
  function automatic void model_req(input logic [31:0] a, input logic [1:0] k,
                                    input logic s, output logic hit, output logic [35:0] pa);
    int f;
    longint unsigned sz, st, fsz, fst, pb, aa;
    f = -1; fsz = 0; fst = 0; hit = 1'b0; pa = '0;
    aa = {32'h0, a};
    for (int i = 0; i < NSEG; i++) begin
      int code;
      code = int'(m_lo[i][4:0]);
      if (code >= 11) begin
        sz = 64'd1 << (code + 1);
        st = {32'h0, m_lo[i][31:12], 12'h000};
        st = st - (st % sz);
        if (aa >= st && aa < st + sz) begin
          f = i; fsz = sz; fst = st;
        end
      end
    end
    if (f >= 0 && k != K_RSV) begin
      int b;
      b = int'(k) + (s ? 3 : 0);
      if (m_hi[f][b]) begin
        pb = {28'h0, m_hi[f][31:8], 12'h000};
        pb = pb - (pb % fsz);
        pa = 36'(pb + (aa - fst));
        hit = 1'b1;
      end
    end
  endfunction

  task automatic step(string tag, logic rv, logic [31:0] a, logic [1:0] k, logic s,
                      logic ce, logic we, logic hi, logic [IW-1:0] idx, logic [31:0] wd);
    logic h;
    logic [35:0] p;
    req_valid = rv; req_addr = a; req_kind = k; req_super = s;
    cfg_en = ce; cfg_we = we; cfg_hi = hi; cfg_idx = idx; cfg_wdata = wd;
    model_req(a, k, s, h, p);
    e_valid = rv;
    e_hit   = rv && h;
    e_fault = rv && !h;
    if (rv) e_pa = h ? p : 36'h0;
    if (ce && !we) e_rd = hi ? m_hi[idx] : m_lo[idx];
    if (ce && we) begin
      if (hi) m_hi[idx] = wd & 32'hFFFF_FF3F;
      else    m_lo[idx] = wd & 32'hFFFF_F01F;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rsp_valid", 64'(rsp_valid), 64'(e_valid));
    chk(tag, "rsp_hit",   64'(rsp_hit),   64'(e_hit));
    chk(tag, "rsp_fault", 64'(rsp_fault), 64'(e_fault));
    chk(tag, "rsp_paddr", 64'(rsp_paddr), 64'(e_pa));
    chk(tag, "cfg_rdata", 64'(cfg_rdata), 64'(e_rd));
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 32'h0, K_RD, 1'b0, 1'b0, 1'b0, 1'b0, '0, 32'h0);
  endtask
  task automatic req(string tag, logic [31:0] a, logic [1:0] k, logic s);
    step(tag, 1'b1, a, k, s, 1'b0, 1'b0, 1'b0, '0, 32'h0);
  endtask
  task automatic wr(string tag, logic [IW-1:0] idx, logic hi, logic [31:0] d);
    step(tag, 1'b0, 32'h0, K_RD, 1'b0, 1'b1, 1'b1, hi, idx, d);
  endtask
  task automatic req_chk(string tag, logic [31:0] a, logic [1:0] k, logic s,
                         logic eh, logic [35:0] ep);
    req(tag, a, k, s);
    chk(tag, "hit (literal)",   64'(rsp_hit),   64'(eh));
    chk(tag, "fault (literal)", 64'(rsp_fault), 64'(!eh));
    chk(tag, "paddr (literal)", 64'(rsp_paddr), 64'(ep));
  endtask
  task automatic rd_chk(string tag, logic [IW-1:0] idx, logic hi, logic [31:0] ev);
    step(tag, 1'b0, 32'h0, K_RD, 1'b0, 1'b1, 1'b0, hi, idx, 32'h0);
    chk(tag, "rdata (literal)", 64'(cfg_rdata), 64'(ev));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_addr = 0; req_kind = 0; req_super = 0;
    cfg_en = 0; cfg_we = 0; cfg_hi = 0; cfg_idx = '0; cfg_wdata = 0;
    for (int i = 0; i < NSEG; i++) begin m_lo[i] = 32'h0; m_hi[i] = 32'h0; end
    m_lo[0] = 32'h0000_001E; m_hi[0] = 32'h0000_003F;
    m_lo[1] = 32'h8000_001E; m_hi[1] = 32'h8000_003F;
    e_valid = 0; e_hit = 0; e_fault = 0; e_pa = 0; e_rd = 0;
    repeat (3) @(negedge clk);
    chk("R7", "reset rsp_valid", 64'(rsp_valid), 64'h0);
    chk("R7", "reset rsp_fault", 64'(rsp_fault), 64'h0);
    chk("R7", "reset rsp_paddr", 64'(rsp_paddr), 64'h0);
    rst_n = 1'b1;

    // R7: reset descriptor contents
    rd_chk("R7", 4'd0, 1'b0, 32'h0000_001E);
    rd_chk("R7", 4'd0, 1'b1, 32'h0000_003F);
    rd_chk("R7", 4'd1, 1'b0, 32'h8000_001E);
    rd_chk("R7", 4'd1, 1'b1, 32'h8000_003F);
    rd_chk("R7", 4'd7, 1'b0, 32'h0000_0000);
    req_chk("R7", 32'h0C00_0000, K_RD, 1'b0, 1'b1, 36'h0_0C00_0000);
    req_chk("R2", 32'h9000_1234, K_WR, 1'b1, 1'b1, 36'h8_1000_1234);
    req_chk("R2", 32'hFFFF_FFFF, K_EX, 1'b0, 1'b1, 36'h8_7FFF_FFFF);
    idle("R1");
    chk("R1", "valid after idle", 64'(rsp_valid), 64'h0);

    // R5: 4 KB window, user read only
    wr("R3", 4'd5, 1'b0, 32'h1234_500B);
    wr("R5", 4'd5, 1'b1, 32'hABCD_EF01);
    req_chk("R5", 32'h1234_5ABC, K_RD, 1'b0, 1'b1, 36'hA_BCDE_FABC);
    req_chk("R5", 32'h1234_5ABC, K_WR, 1'b0, 1'b0, 36'h0);
    req_chk("R5", 32'h1234_5ABC, K_RD, 1'b1, 1'b0, 36'h0);
    req_chk("R5", 32'h1234_5ABC, K_EX, 1'b0, 1'b0, 36'h0);
    req_chk("R4", 32'h1234_6000, K_RD, 1'b0, 1'b1, 36'h0_1234_6000);
    req_chk("R6", 32'h1234_5ABC, K_RSV, 1'b0, 1'b0, 36'h0);

    // R10: 64 KB window with stray low base bits
    wr("R10", 4'd3, 1'b0, 32'h1234_5F0F);
    wr("R10", 4'd3, 1'b1, 32'h3000_073F);
    req_chk("R4", 32'h1234_5ABC, K_RD, 1'b0, 1'b1, 36'hA_BCDE_FABC);
    req_chk("R10", 32'h1234_9876, K_WR, 1'b1, 1'b1, 36'h3_0000_9876);
    wr("R3", 4'd5, 1'b0, 32'h1234_5000);
    req_chk("R3", 32'h1234_5ABC, K_RD, 1'b0, 1'b1, 36'h3_0000_5ABC);

    // R8: masking, R3: 4 GB window on descriptor 9
    wr("R8", 4'd9, 1'b0, 32'hFFFF_FFFF);
    wr("R8", 4'd9, 1'b1, 32'hFFFF_FFFF);
    rd_chk("R8", 4'd9, 1'b0, 32'hFFFF_F01F);
    rd_chk("R8", 4'd9, 1'b1, 32'hFFFF_FF3F);
    wr("R8", 4'd2, 1'b0, 32'h0000_0000);
    chk("R8", "rdata held over write", 64'(cfg_rdata), 64'hFFFF_FF3F);
    req_chk("R3", 32'h1234_5ABC, K_EX, 1'b1, 1'b1, 36'hF_1234_5ABC);
    req_chk("R4", 32'h0C00_0000, K_RD, 1'b0, 1'b1, 36'hF_0C00_0000);
    wr("R3", 4'd9, 1'b0, 32'h0000_000A);
    req_chk("R3", 32'h0C00_0000, K_RD, 1'b0, 1'b1, 36'h0_0C00_0000);

    // R9: write and request in the same cycle
    step("R9", 1'b1, 32'h2000_0000, K_RD, 1'b0, 1'b1, 1'b1, 1'b0, 4'd12, 32'h2000_000B);
    chk("R9", "old mapping used", 64'(rsp_paddr), 64'h0_2000_0000);
    req_chk("R9", 32'h2000_0000, K_RD, 1'b0, 1'b0, 36'h0);

    // R6: remove both reset windows
    wr("R6", 4'd0, 1'b0, 32'h0);
    wr("R6", 4'd1, 1'b0, 32'h0);
    req_chk("R6", 32'h4000_0000, K_RD, 1'b1, 1'b0, 36'h0);
    req_chk("R6", 32'h8000_0000, K_RD, 1'b1, 1'b0, 36'h0);
    wr("R7", 4'd0, 1'b0, 32'h0000_001E);
    wr("R7", 4'd1, 1'b0, 32'h8000_001E);

    // Mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r, a;
      r = $urandom;
      case (r[2:0])
        3'd0: wr("R4", IW'($urandom), r[3], $urandom);
        3'd1: idle("R1");
        default: begin
          a = $urandom;
          case (r[5:4])
            2'd0: a = {16'h1234, a[15:0]};
            2'd1: a = {20'h20000, a[11:0]};
            2'd2: a = {1'b1, a[30:0]};
            default: ;
          endcase
          req("R2", a, 2'(r[7:6]), r[8]);
        end
      endcase
    end
    idle("R1");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule